// File: doc/BRIEF.md
# Bidirectional Radix-Centred Leading-One Normaliser

This block normalises a wide fixed-point sum whose radix point lies inside the word. A sum and its exponent enter over a valid/ready stream. The block then walks outward from the radix point, probing one bit above it and one bit below it on every clock. When the walk ends, it shifts the sum so that its leading one sits just above the radix point and corrects the exponent by the same distance. The block is intended to sit between a fused multiply-add datapath and its rounding stage.

The sum is three significand widths wide (159 bits for a 53-bit significand). The radix point lies between bit 104 and bit 103, so bit 104 is the unit position. Above the radix, the probe keeps the distance of the highest one it finds. Below the radix, it keeps the distance of the one nearest the point. Any one at or above the radix takes priority, and the block then shifts right; otherwise it shifts left.

The input accepts a sum only when `in_ready` is high. A sum presented while the block is busy waits and is not taken. A result stays on the output pins, unchanged, until `out_ready` takes it. The block holds one operation at a time.

Top module: `bilod_top`

## Requirements
- R1: After reset `in_ready` is high, `busy` is low and `out_valid` is low. A sum is taken at a clock edge where `in_valid` and `in_ready` are both high, and `busy` is high from the next cycle until the result has been taken.
- R2: `out_valid` rises exactly STEPS+1 clock edges after the accepting edge, where STEPS is the larger of the 104 lower and 55 upper bit positions, which gives 105 edges by default.
- R3: For a non-zero sum, `out_sig` equals bits 104 down to 52 of the shifted sum, and its most significant bit is 1.
- R4: If any bit at index 104 or above is 1, then `out_rshift` equals (index of the highest 1) − 104, `out_lshift` is 0 and `out_right` is 1. Ones below the radix do not influence the shift in this case.
- R5: If no bit at index 104 or above is 1 and the sum is non-zero, then `out_lshift` equals 104 − (index of the highest 1), `out_rshift` is 0 and `out_right` is 0.
- R6: `out_exp` equals `in_exp` + `out_rshift` on a right shift and `in_exp` − `out_lshift` on a left shift, modulo 2^EXP_W.
- R7: An all-zero sum gives `out_zero` = 1, both shift counts 0, `out_right` = 0, `out_sig` = 0 and `out_exp` equal to `in_exp`.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and every result field stays constant. After the edge at which both are high, `out_valid` is low and `in_ready` is high.
- R9: An `in_valid` pulse while `busy` is high is not taken. The result of the operation in progress still reflects the sum that was originally accepted.
- R10: A sum whose highest 1 is exactly bit 104, with other ones set below the radix, gives a right shift of 0 with `out_right` = 1 and no left shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sum and exponent offered |
| in_ready | output | 1 | Block is idle and will take an offered sum |
| in_sum | input | 3*SIG_W | Sum to normalise; radix point below bit 2*SIG_W-2 |
| in_exp | input | EXP_W | Exponent that belongs to the sum |
| busy | output | 1 | An operation is in progress or its result is waiting |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_sig | output | SIG_W | Normalised significand, leading one in the MSB |
| out_exp | output | EXP_W | Corrected exponent |
| out_rshift | output | CNT_W | Right-shift distance applied |
| out_lshift | output | CNT_W | Left-shift distance applied |
| out_right | output | 1 | 1 when the right-shift path was taken |
| out_zero | output | 1 | Sum was all zeros |

## Verification
Two events can fall in the same cycle: the consumer takes a held result, and the producer offers the next sum. The bench keeps a new operand on `in_valid` for the whole scan and through the release edge, and it stalls `out_ready` for a random number of cycles. The bench then judges three things. The result fields must not move during the stall. The result must still match the original operand. At the release edge the block must go idle without taking the waiting operand.

// File: rtl/bilod_pkg.sv
package bilod_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SCAN,
    ST_FIN,
    ST_HOLD
  } bilod_state_e;
endpackage

// File: rtl/bilod_probe.sv
// Selects the bit under test on one side of the radix for the current step.
module bilod_probe #(
  parameter int SUM_W = 159,
  parameter int RADIX = 104,
  parameter int CNT_W = 7,
  parameter bit UPPER = 1'b1
) (
  input  logic [SUM_W-1:0] sum,
  input  logic [CNT_W-1:0] count,
  output logic             hit
);
  localparam int SPAN = UPPER ? (SUM_W - RADIX) : RADIX;

  generate
    if (UPPER) begin : g_up
      always_comb begin
        hit = 1'b0;
        for (int i = 0; i < SPAN; i++) begin
          if (count == CNT_W'(i)) hit = sum[RADIX + i];
        end
      end
    end else begin : g_lo
      always_comb begin
        hit = 1'b0;
        for (int i = 0; i < SPAN; i++) begin
          if (count == CNT_W'(i)) hit = sum[RADIX - 1 - i];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/bilod_marker.sv
// Holds the shift distance for one side; KEEP_FIRST picks the update policy.
module bilod_marker #(
  parameter int CNT_W      = 7,
  parameter bit KEEP_FIRST = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic             hit,
  input  logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] mark,
  output logic             found
);
  generate
    if (KEEP_FIRST) begin : g_first
      // Lower side: first one met is the one nearest the radix.
      always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
          mark  <= '0;
          found <= 1'b0;
        end else if (step && hit && !found) begin
          mark  <= count + CNT_W'(1);
          found <= 1'b1;
        end
      end
    end else begin : g_last
      // Upper side: every one overwrites, so the highest one wins.
      always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
          mark  <= '0;
          found <= 1'b0;
        end else if (step && hit) begin
          mark  <= count;
          found <= 1'b1;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/bilod_norm.sv
// Applies the chosen shift and corrects the exponent (combinational).
module bilod_norm #(
  parameter int SUM_W = 159,
  parameter int SIG_W = 53,
  parameter int RADIX = 104,
  parameter int CNT_W = 7,
  parameter int EXP_W = 13
) (
  input  logic [SUM_W-1:0] sum,
  input  logic [EXP_W-1:0] exp_in,
  input  logic [CNT_W-1:0] up_mark,
  input  logic             up_found,
  input  logic [CNT_W-1:0] lo_mark,
  input  logic             lo_found,
  output logic [SIG_W-1:0] sig,
  output logic [EXP_W-1:0] exp_out,
  output logic [CNT_W-1:0] rshift,
  output logic [CNT_W-1:0] lshift,
  output logic             right,
  output logic             zero
);
  logic [SUM_W-1:0] shifted;

  always_comb begin
    right   = up_found;
    zero    = !up_found && !lo_found;
    rshift  = '0;
    lshift  = '0;
    shifted = sum;
    exp_out = exp_in;
    if (up_found) begin
      rshift  = up_mark;
      shifted = sum >> up_mark;
      exp_out = exp_in + EXP_W'(up_mark);
    end else if (lo_found) begin
      lshift  = lo_mark;
      shifted = sum << lo_mark;
      exp_out = exp_in - EXP_W'(lo_mark);
    end
    sig = shifted[RADIX -: SIG_W];
  end
endmodule

// File: rtl/bilod_top.sv
module bilod_top #(
  parameter int  SIG_W   = 53,
  parameter int  EXP_W   = 13,
  localparam int SUM_W   = 3 * SIG_W,
  localparam int RADIX   = 2 * SIG_W - 2,
  localparam int LO_BITS = RADIX,
  localparam int UP_BITS = SUM_W - RADIX,
  localparam int STEPS   = (LO_BITS > UP_BITS) ? LO_BITS : UP_BITS,
  localparam int CNT_W   = $clog2(STEPS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [SUM_W-1:0] in_sum,
  input  logic [EXP_W-1:0] in_exp,
  output logic             busy,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [SIG_W-1:0] out_sig,
  output logic [EXP_W-1:0] out_exp,
  output logic [CNT_W-1:0] out_rshift,
  output logic [CNT_W-1:0] out_lshift,
  output logic             out_right,
  output logic             out_zero
);
  import bilod_pkg::*;

  bilod_state_e     state;
  logic [CNT_W-1:0] count;
  logic [SUM_W-1:0] sum_q;
  logic [EXP_W-1:0] exp_q;
  logic             accept, scanning, last_step;
  logic             up_hit, lo_hit, up_found, lo_found;
  logic [CNT_W-1:0] up_mark, lo_mark;
  logic [SIG_W-1:0] n_sig;
  logic [EXP_W-1:0] n_exp;
  logic [CNT_W-1:0] n_rsh, n_lsh;
  logic             n_right, n_zero;

  assign in_ready  = (state == ST_IDLE);
  assign busy      = (state != ST_IDLE);
  assign accept    = in_valid && in_ready;
  assign scanning  = (state == ST_SCAN);
  assign last_step = (count == CNT_W'(STEPS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      count <= '0;
      sum_q <= '0;
      exp_q <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          sum_q <= in_sum;
          exp_q <= in_exp;
          count <= '0;
          state <= ST_SCAN;
        end
        ST_SCAN: begin
          count <= count + CNT_W'(1);
          if (last_step) state <= ST_FIN;
        end
        ST_FIN:  state <= ST_HOLD;
        ST_HOLD: if (out_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  bilod_probe #(.SUM_W(SUM_W), .RADIX(RADIX), .CNT_W(CNT_W), .UPPER(1'b1)) u_probe_up (
    .sum(sum_q), .count(count), .hit(up_hit)
  );
  bilod_probe #(.SUM_W(SUM_W), .RADIX(RADIX), .CNT_W(CNT_W), .UPPER(1'b0)) u_probe_lo (
    .sum(sum_q), .count(count), .hit(lo_hit)
  );

  bilod_marker #(.CNT_W(CNT_W), .KEEP_FIRST(1'b0)) u_mark_up (
    .clk(clk), .rst_n(rst_n), .clr(accept), .step(scanning), .hit(up_hit),
    .count(count), .mark(up_mark), .found(up_found)
  );
  bilod_marker #(.CNT_W(CNT_W), .KEEP_FIRST(1'b1)) u_mark_lo (
    .clk(clk), .rst_n(rst_n), .clr(accept), .step(scanning), .hit(lo_hit),
    .count(count), .mark(lo_mark), .found(lo_found)
  );

  bilod_norm #(
    .SUM_W(SUM_W), .SIG_W(SIG_W), .RADIX(RADIX), .CNT_W(CNT_W), .EXP_W(EXP_W)
  ) u_norm (
    .sum(sum_q), .exp_in(exp_q), .up_mark(up_mark), .up_found(up_found),
    .lo_mark(lo_mark), .lo_found(lo_found), .sig(n_sig), .exp_out(n_exp),
    .rshift(n_rsh), .lshift(n_lsh), .right(n_right), .zero(n_zero)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_sig    <= '0;
      out_exp    <= '0;
      out_rshift <= '0;
      out_lshift <= '0;
      out_right  <= 1'b0;
      out_zero   <= 1'b0;
    end else if (state == ST_FIN) begin
      out_valid  <= 1'b1;
      out_sig    <= n_sig;
      out_exp    <= n_exp;
      out_rshift <= n_rsh;
      out_lshift <= n_lsh;
      out_right  <= n_right;
      out_zero   <= n_zero;
    end else if (state == ST_HOLD && out_ready) begin
      out_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/bilod_checker.sv
module bilod_checker #(
  parameter int  SIG_W   = 53,
  parameter int  EXP_W   = 13,
  localparam int SUM_W   = 3 * SIG_W,
  localparam int RADIX   = 2 * SIG_W - 2,
  localparam int UP_BITS = SUM_W - RADIX,
  localparam int STEPS   = (RADIX > UP_BITS) ? RADIX : UP_BITS,
  localparam int CNT_W   = $clog2(STEPS + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             busy,
  input logic             out_valid,
  input logic             out_ready,
  input logic [SIG_W-1:0] out_sig,
  input logic [EXP_W-1:0] out_exp,
  input logic [CNT_W-1:0] out_rshift,
  input logic [CNT_W-1:0] out_lshift,
  input logic             out_right,
  input logic             out_zero
);
  a_r1_take_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> busy);

  a_r9_no_take_busy: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && busy && !out_valid |=> busy && !in_ready);

  a_r3_lead_one: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_zero |-> out_sig[SIG_W-1]);

  a_r4_one_side: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_rshift == '0) || (out_lshift == '0));

  a_r5_left_no_rshift: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_right |-> out_rshift == '0);

  a_r7_zero_clean: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_zero |-> out_sig == '0 && out_rshift == '0 && out_lshift == '0 && !out_right);

  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_sig) && $stable(out_exp)
      && $stable(out_rshift) && $stable(out_lshift) && $stable(out_right) && $stable(out_zero));

  a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> !out_valid && in_ready);
endmodule

bind bilod_top bilod_checker #(.SIG_W(SIG_W), .EXP_W(EXP_W)) u_bilod_checker (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .busy(busy),
  .out_valid(out_valid), .out_ready(out_ready), .out_sig(out_sig), .out_exp(out_exp),
  .out_rshift(out_rshift), .out_lshift(out_lshift), .out_right(out_right),
  .out_zero(out_zero)
);

// File: tb/test_bilod_top.sv
module test_bilod_top;
  localparam int CLK_PERIOD = 10;
  localparam int SIG_W = 53;
  localparam int EXP_W = 13;
  localparam int SUM_W = 159;
  localparam int RADIX = 104;
  localparam int STEPS = 104;
  localparam int CNT_W = 7;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [SUM_W-1:0] in_sum = '0;
  logic [EXP_W-1:0] in_exp = '0;
  logic             busy;
  logic             out_valid;
  logic             out_ready = 1'b0;
  logic [SIG_W-1:0] out_sig;
  logic [EXP_W-1:0] out_exp;
  logic [CNT_W-1:0] out_rshift, out_lshift;
  logic             out_right, out_zero;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bilod_top #(.SIG_W(SIG_W), .EXP_W(EXP_W)) i_bilod_top (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sum(in_sum), .in_exp(in_exp), .busy(busy), .out_valid(out_valid),
    .out_ready(out_ready), .out_sig(out_sig), .out_exp(out_exp),
    .out_rshift(out_rshift), .out_lshift(out_lshift), .out_right(out_right),
    .out_zero(out_zero)
  );

  task automatic chk(input bit ok, input string tag, input logic [255:0] act,
                     input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Expected result from the requirements: find the highest one, pick the side.
  task automatic model(input logic [SUM_W-1:0] s, input logic [EXP_W-1:0] e,
                       output logic [SIG_W-1:0] sig, output logic [EXP_W-1:0] eo,
                       output int rs, output int ls, output bit rt, output bit zr);
    int h;
    logic [SUM_W-1:0] sh;
    h = -1;
    for (int i = 0; i < SUM_W; i++) if (s[i]) h = i;
    rs = 0; ls = 0; rt = 1'b0; zr = 1'b0; eo = e; sh = s;
    if (h < 0) zr = 1'b1;
    else if (h >= RADIX) begin
      rt = 1'b1; rs = h - RADIX; sh = s >> rs; eo = e + EXP_W'(rs);
    end else begin
      ls = RADIX - h; sh = s << ls; eo = e - EXP_W'(ls);
    end
    sig = zr ? '0 : sh[RADIX -: SIG_W];
  endtask

  task automatic run_op(input logic [SUM_W-1:0] s, input logic [EXP_W-1:0] e,
                        input int hold, input bit interfere, input string note);
    logic [SIG_W-1:0] esig;
    logic [EXP_W-1:0] eexp;
    int ers, els, n;
    bit ert, ezr;
    string ptag;
    model(s, e, esig, eexp, ers, els, ert, ezr);
    ptag = ezr ? "R7" : (ert ? "R4" : "R5");
    @(negedge clk);
    in_sum = s; in_exp = e; in_valid = 1'b1; out_ready = 1'b0;
    chk(in_ready == 1'b1, "R1 idle ready", in_ready, 1);
    @(posedge clk);
    @(negedge clk);
    chk(busy == 1'b1 && in_ready == 1'b0, "R1 busy after take", {busy, in_ready}, 2'b10);
    if (interfere) begin
      in_sum = ~s; in_exp = ~e;     // R9: offered while busy
    end else begin
      in_valid = 1'b0;
    end
    n = 0;
    while (!out_valid && n < 400) begin
      @(posedge clk); @(negedge clk); n++;
    end
    chk(n == STEPS + 1, "R2 latency", n, STEPS + 1);
    chk(out_sig == esig, {"R3 significand ", note}, out_sig, esig);
    chk(out_rshift == CNT_W'(ers) && out_lshift == CNT_W'(els) && out_right == ert,
        {ptag, " shift ", note}, {out_right, out_rshift, out_lshift},
        {ert, CNT_W'(ers), CNT_W'(els)});
    chk(out_zero == ezr, {"R7 zero flag ", note}, out_zero, ezr);
    chk(out_exp == eexp, {"R6 exponent ", note}, out_exp, eexp);
    for (int k = 0; k < hold; k++) begin
      @(posedge clk); @(negedge clk);
      chk(out_valid && out_sig == esig && out_exp == eexp && out_rshift == CNT_W'(ers)
          && out_lshift == CNT_W'(els), "R8 hold stable", {out_valid, out_sig}, {1'b1, esig});
    end
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b0;
    chk(!out_valid && in_ready, "R8 release", {out_valid, in_ready}, 2'b01);
    if (interfere)
      chk(!busy, "R9 busy offer not taken", busy, 0);
  endtask

  initial begin
    logic [SUM_W-1:0] s;
    void'($urandom(32'h5eed_0417));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready && !busy && !out_valid, "R1 reset state", {in_ready, busy, out_valid}, 3'b100);

    run_op('0, 13'h0400, 1, 1'b0, "all zero R7");
    run_op({1'b1, 158'b0}, 13'h0400, 0, 1'b0, "top bit R4");
    run_op(159'b1, 13'h0400, 0, 1'b0, "bottom bit R5");
    s = '0; s[RADIX] = 1'b1; s[3] = 1'b1; s[RADIX-1] = 1'b1;
    run_op(s, 13'h0100, 0, 1'b0, "unit bit with lower ones R10");
    s = '0; s[RADIX-1] = 1'b1; s[0] = 1'b1;
    run_op(s, 13'h0100, 2, 1'b0, "first below radix R5");
    s = '0; s[RADIX+1] = 1'b1; s[RADIX-2] = 1'b1;
    run_op(s, 13'h0000, 0, 1'b1, "exp wrap R6");
    s = '0; s[RADIX-50] = 1'b1;
    run_op(s, 13'h0005, 3, 1'b1, "exp wrap down R6");

    for (int t = 0; t < 200; t++) begin
      s = {$urandom, $urandom, $urandom, $urandom, $urandom};
      s = s >> $urandom_range(0, SUM_W - 1);
      run_op(s, EXP_W'($urandom), int'($urandom_range(0, 3)), bit'($urandom_range(0, 1)),
             "random");
    end

    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog R2 actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule